// File: doc/BRIEF.md
# Four-Pad Multitap Nibble Sequencer

This block stands in for a four-player multitap adapter on a host's controller port. The host drives two lines: a select line (TH) and a strobe line (TR). A 16-entry table of 4-bit nibbles holds the pad data. A writer on the local side keeps the table current. The block streams the table to the host one nibble at a time.

Any TH transition sets the read position to the inverse of the new TH level. While TH is low, each TR transition, rising or falling, moves the position on by one and wraps after the last entry. Bit 4 of the output always carries the most recent TR level back to the host, which serves as the acknowledge of the handshake.

Both host lines pass through two synchronizing flops. The output is held in a register. That register changes only when a TH or TR transition is seen, so a table write never alters the nibble the host is currently reading.

Top module: `quad_pad_streamer`

## Requirements
- R1: While reset is asserted and right after its release, `dataOut` is {TR level, 4'hF}; every table entry resets to 4'hF, meaning no pad present and nothing pressed.
- R2: A falling TH transition sets the position to 1, and the output becomes {TR, table[1]}.
- R3: A rising TH transition sets the position to 0, and the output becomes {TR, table[0]}.
- R4: While TH is low, every TR transition in either direction raises the position by one, and the output shows {TR, table[new position]}.
- R5: The position wraps from 15 to 0.
- R6: While TH is high, TR transitions do not move the position. The output nibble stays at table[0] and only bit 4 follows TR.
- R7: After every update, `dataOut[4]` equals the TR level that caused the update. The output changes on the third rising clock edge after a pin change, counting the two synchronizer stages and the output register.
- R8: When TH and TR change in the same cycle, the TH rule decides the position (R2/R3) and TR does not advance it. Bit 4 still takes the new TR level.
- R9: A write (`wrEn` high, entry `wrAddr` takes `wrData`) leaves `dataOut` unchanged. The written value shows up at the next pin-triggered update that selects that entry. With no pin transition, `dataOut` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| thPin | input | 1 | Host select line, asynchronous |
| trPin | input | 1 | Host strobe line, asynchronous |
| wrEn | input | 1 | Table write enable |
| wrAddr | input | 4 | Table entry to write |
| wrData | input | 4 | Nibble to store |
| dataOut | output | 5 | {TR echo, current nibble} toward the host |

## Verification
The bound checker inspects the control strobes and the position on every cycle. It checks that a TH fall yields position 1 and a TH rise yields position 0. It checks that an advance steps the position by one with wrap, that TH high freezes the position, and that TH and advance are never active together. It also checks that bit 4 echoes the TR level after every update and that the output holds when no update occurs.

Other behaviour can only be shown by the bench's scenarios. These include the actual nibble values the host receives for a table it has loaded, the three-edge latency from the pins, and the full wrap across all sixteen entries. They also include the case where a write to the entry being driven stays invisible until the next strobe.

// File: rtl/qps_pkg.sv
package qps_pkg;
  // Strobes handed from control to datapath once per clock.
  typedef struct packed {
    logic thEdge;   // TH changed this cycle
    logic thLevel;  // synchronized TH level
    logic trLevel;  // synchronized TR level
    logic advance;  // step position by one
    logic update;   // reload the output register
  } ctlStrobes_t;
endpackage

// File: rtl/qps_sync.sv
module qps_sync #(
  parameter int Width  = 2,
  parameter int Stages = 2
) (
  input  logic             clk,
  input  logic [Width-1:0] din,
  output logic [Width-1:0] dout
);
  logic [Width-1:0] chain [Stages];

  generate
    for (genvar s = 0; s < Stages; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) chain[s] <= din;
      end else begin : g_next
        always_ff @(posedge clk) chain[s] <= chain[s-1];
      end
    end
  endgenerate

  assign dout = chain[Stages-1];
endmodule

// File: rtl/qps_ctl.sv
module qps_ctl
  import qps_pkg::*;
#(
  parameter int SyncStages = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        thPin,
  input  logic        trPin,
  output ctlStrobes_t strobes
);
  logic [1:0] syncedPins;
  logic       thLevel, trLevel;
  logic       thPrev, trPrev;
  logic       thEdge, trEdge;

  qps_sync #(.Width(2), .Stages(SyncStages)) u_sync (
    .clk (clk),
    .din ({thPin, trPin}),
    .dout(syncedPins)
  );

  assign thLevel = syncedPins[1];
  assign trLevel = syncedPins[0];

  // During reset the history follows the pins, so release gives no false edge.
  always_ff @(posedge clk) begin
    thPrev <= thLevel;
    trPrev <= trLevel;
  end

  assign thEdge = !rst && (thLevel != thPrev);
  assign trEdge = !rst && (trLevel != trPrev);

  always_comb begin
    strobes.thEdge  = thEdge;
    strobes.thLevel = thLevel;
    strobes.trLevel = trLevel;
    strobes.advance = trEdge && !thEdge && !thLevel;
    strobes.update  = thEdge || trEdge;
  end
endmodule

// File: rtl/qps_datapath.sv
module qps_datapath
  import qps_pkg::*;
#(
  parameter int NumEntries = 16,
  parameter int NibbleW    = 4,
  localparam int PosW      = $clog2(NumEntries)
) (
  input  logic              clk,
  input  logic              rst,
  input  ctlStrobes_t       strobes,
  input  logic              wrEn,
  input  logic [PosW-1:0]   wrAddr,
  input  logic [NibbleW-1:0] wrData,
  output logic [PosW-1:0]   position,
  output logic [NibbleW:0]  dataOut
);
  localparam logic [PosW-1:0] LastPos = PosW'(NumEntries - 1);

  logic [NibbleW-1:0] nibTable [NumEntries];
  logic [PosW-1:0]    posNext;

  generate
    for (genvar e = 0; e < NumEntries; e++) begin : g_entry
      always_ff @(posedge clk) begin
        if (rst) begin
          nibTable[e] <= '1;
        end else if (wrEn && (wrAddr == PosW'(e))) begin
          nibTable[e] <= wrData;
        end
      end
    end
  endgenerate

  always_comb begin
    posNext = position;
    if (strobes.thEdge) begin
      posNext = strobes.thLevel ? '0 : PosW'(1);
    end else if (strobes.advance) begin
      posNext = (position == LastPos) ? '0 : position + PosW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      position <= '0;
      dataOut  <= {strobes.trLevel, {NibbleW{1'b1}}};
    end else if (strobes.update) begin
      position <= posNext;
      dataOut  <= {strobes.trLevel, nibTable[posNext]};
    end
  end
endmodule

// File: rtl/quad_pad_streamer.sv
module quad_pad_streamer
  import qps_pkg::*;
#(
  parameter int NumEntries = 16,
  parameter int NibbleW    = 4,
  parameter int SyncStages = 2,
  localparam int PosW      = $clog2(NumEntries)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               thPin,
  input  logic               trPin,
  input  logic               wrEn,
  input  logic [PosW-1:0]    wrAddr,
  input  logic [NibbleW-1:0] wrData,
  output logic [NibbleW:0]   dataOut
);
  ctlStrobes_t     ctlStrobes;
  logic [PosW-1:0] curPos;

  qps_ctl #(.SyncStages(SyncStages)) u_ctl (
    .clk    (clk),
    .rst    (rst),
    .thPin  (thPin),
    .trPin  (trPin),
    .strobes(ctlStrobes)
  );

  qps_datapath #(.NumEntries(NumEntries), .NibbleW(NibbleW)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobes (ctlStrobes),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .position(curPos),
    .dataOut (dataOut)
  );
endmodule

// File: rtl/qps_checker.sv
module qps_checker
  import qps_pkg::*;
#(
  parameter int NumEntries = 16,
  parameter int NibbleW    = 4,
  localparam int PosW      = $clog2(NumEntries)
) (
  input logic             clk,
  input logic             rst,
  input ctlStrobes_t      strobes,
  input logic [PosW-1:0]  position,
  input logic [NibbleW:0] dataOut
);
  a_r2_fall_pos_one: assert property (@(posedge clk) disable iff (rst)
    strobes.thEdge && !strobes.thLevel |=> position == PosW'(1));

  a_r3_rise_pos_zero: assert property (@(posedge clk) disable iff (rst)
    strobes.thEdge && strobes.thLevel |=> position == '0);

  // R4 and R5: one step per advance, wrapping at the last entry
  a_r4_step_wraps: assert property (@(posedge clk) disable iff (rst)
    strobes.advance |=>
      position == PosW'((int'($past(position)) + 1) % NumEntries));

  a_r6_th_high_holds: assert property (@(posedge clk) disable iff (rst)
    strobes.thLevel && !strobes.thEdge |=> $stable(position));

  a_r7_bit4_echo: assert property (@(posedge clk) disable iff (rst)
    strobes.update |=> dataOut[NibbleW] == $past(strobes.trLevel));

  a_r8_th_priority: assert property (@(posedge clk) disable iff (rst)
    !(strobes.advance && strobes.thEdge));

  a_r9_hold_without_update: assert property (@(posedge clk) disable iff (rst)
    !rst && !strobes.update |=> $stable(dataOut));
endmodule

bind quad_pad_streamer qps_checker #(.NumEntries(NumEntries), .NibbleW(NibbleW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .strobes (ctlStrobes),
  .position(curPos),
  .dataOut (dataOut)
);

// File: tb/quad_pad_streamer_tb.sv
module quad_pad_streamer_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       thPin = 1'b1;
  logic       trPin = 1'b0;
  logic       wrEn = 1'b0;
  logic [3:0] wrAddr = '0;
  logic [3:0] wrData = '0;
  logic [4:0] dataOut;

  typedef struct {
    logic [4:0] val;
    int         due;
    string      tag;
  } expItem_t;

  expItem_t   expQ[$];
  int         cycle = 0;
  int         nChecks = 0;
  int         nFails = 0;
  logic [3:0] mTable [16];
  int         mPos = 0;
  logic       mTh = 1'b1;
  logic       mTr = 1'b0;
  logic [4:0] mOut = 5'h0F;
  bit         done = 0;

  quad_pad_streamer u_dut (
    .clk(clk), .rst(rst), .thPin(thPin), .trPin(trPin),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .dataOut(dataOut)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cycle <= cycle + 1;

  // monitor: pops expected items when due and compares
  initial begin
    forever begin
      @(negedge clk);
      while (expQ.size() > 0 && expQ[0].due <= cycle) begin
        expItem_t it;
        it = expQ.pop_front();
        nChecks++;
        if (it.due != cycle || dataOut !== it.val) begin
          nFails++;
          $display("FAIL %s: dataOut=%h expected=%h", it.tag, dataOut, it.val);
        end
      end
    end
  end

  task automatic expectAt(int delay, logic [4:0] v, string tag);
    expItem_t it;
    it.val = v; it.due = cycle + delay; it.tag = tag;
    expQ.push_back(it);
  endtask

  // drive pins at a negedge, predict the output three edges later
  task automatic pins(logic newTh, logic newTr, string tag);
    bit changed;
    changed = (newTh != mTh) || (newTr != mTr);
    if (newTh != mTh) mPos = newTh ? 0 : 1;
    else if (newTr != mTr && !newTh) mPos = (mPos + 1) % 16;
    mTh = newTh; mTr = newTr;
    if (changed) mOut = {mTr, mTable[mPos]};
    thPin = newTh; trPin = newTr;
    expectAt(2, mOut, tag);   // not yet visible
    expectAt(3, mOut, tag);
    if (changed && cycle > 0) begin
      // value two edges in must still be the old one
      expQ[expQ.size()-2].val = expQ.size() > 0 ? prevOut : mOut;
    end
    prevOut = mOut;
    repeat (4) @(negedge clk);
  endtask

  logic [4:0] prevOut = 5'h0F;

  task automatic writeEntry(int addr, logic [3:0] val);
    wrEn = 1'b1; wrAddr = 4'(addr); wrData = val;
    mTable[addr] = val;
    expectAt(1, mOut, "R9 write leaves output");
    expectAt(2, mOut, "R9 write leaves output");
    @(negedge clk);
    wrEn = 1'b0;
    @(negedge clk);
  endtask

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: run did not finish");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) mTable[i] = 4'hF;
    repeat (6) @(negedge clk);
    // R1: reset value while reset held
    nChecks++;
    if (dataOut !== 5'h0F) begin
      nFails++; $display("FAIL R1 in reset: dataOut=%h expected=0f", dataOut);
    end
    rst = 1'b0;
    expectAt(1, 5'h0F, "R1 after release");
    expectAt(3, 5'h0F, "R1 no spurious edge");
    repeat (4) @(negedge clk);

    // R9: load a distinct table, output must not move
    for (int i = 0; i < 16; i++) writeEntry(i, 4'((i * 7 + 3) & 15));

    // R6/R7: TH high, TR toggles echo on bit 4, nibble stays table[0]
    pins(1'b1, 1'b1, "R6 TR rise with TH high");
    pins(1'b1, 1'b0, "R6 TR fall with TH high");
    pins(1'b1, 1'b1, "R7 TR echo");

    // R2: TH falls -> entry 1
    pins(1'b0, 1'b1, "R2 TH fall");
    // R4/R5: walk past the end of the table
    for (int k = 0; k < 17; k++) pins(1'b0, (k % 2 == 0) ? 1'b0 : 1'b1, "R4 R5 TR step");
    // R3: TH rises -> entry 0
    pins(1'b1, mTr, "R3 TH rise");
    // R8: both change together
    pins(1'b0, ~mTr, "R8 TH fall with TR");
    pins(1'b0, ~mTr, "R4 TR step after fall");
    pins(1'b1, ~mTr, "R8 TH rise with TR");

    // R9: rewrite the upcoming entry, visible only after next strobe
    pins(1'b0, mTr, "R2 TH fall again");
    writeEntry(2, 4'h5);
    writeEntry(1, 4'h9);
    pins(1'b0, ~mTr, "R9 new value at next step");
    pins(1'b0, mTr, "R4 step to 3");

    repeat (6) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule